// File: doc/BRIEF.md
# Segment Access-Rights Loader

This unit resolves a 16-bit segment selector into the access-rights image of the descriptor it names. A single-cycle `start_i` pulse hands it the selector, the destination width, the current privilege level and the present value of the destination register. The unit then works through a fixed series of steps:

- It rejects a null selector.
- It picks the global or the local descriptor table and checks that the whole 8-byte descriptor lies inside that table's limit.
- It fetches the upper 32-bit word of the descriptor over a single-outstanding request/response memory port.
- It checks the descriptor type and the privilege of the descriptor.

For every operation the unit raises a one-cycle `done_o`. When all checks pass, `zf_o` is 1 and `result_o` carries the masked rights image merged into the destination. When any check fails, `zf_o` is 0 and `result_o` returns the destination value unchanged.

Only the low 16 bits of a wider source operand are meaningful, so the caller passes only those 16 bits to `sel_i`. The descriptor tables must not change while `busy_o` is high.

Top module: `seg_rights_loader`

## Requirements
- R1: A null selector (bits 15:2 all zero, that is index 0 in the global table, whatever the RPL in bits 1:0) fails. `zf_o` is 0, `result_o` equals the captured destination, and no memory request is issued.
- R2: With index = selector bits 15:3 and offset = index*8, the limit check passes only when offset+7 is no greater than the selected table's limit. Otherwise the operation fails with no memory request.
- R3: Selector bit 2 selects the local table when 1 and the global table when 0. The single fetch reads address table base + offset + 4.
- R4: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_ready_i` is seen. Exactly one request handshake occurs per operation that passes R1 and R2.
- R5: When descriptor word bit 12 is 1 (code or data), every type code in bits 11:8 is accepted, subject to R7.
- R6: When bit 12 is 0, only these system type codes in bits 11:8 are accepted: 1, 2, 3, 4, 5, 9, 11 and 12. Every other code fails.
- R7: DPL is bits 14:13 of the descriptor word. A non-conforming descriptor fails when DPL < max(CPL, RPL). A conforming code descriptor (bit 12 = 1, bit 11 = 1, bit 10 = 1) is exempt from this check.
- R8: Size code 1 (32-bit) yields `{dest[63:32], word & 32'h00FFFF00}`.
- R9: Size code 0 (16-bit) yields `{dest[63:16], word[15:8], 8'h00}`.
- R10: Size codes 2 and 3 (64-bit) yield the 32-bit masked value zero-extended to 64 bits.
- R11: Every operation ends with `done_o` high for exactly one cycle. `zf_o` is 1 if and only if all checks passed.
- R12: A `start_i` seen while the unit is busy, including the cycle in which `done_o` is high, is ignored. It does not alter the running result and does not launch a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| sel_i | input | 16 | Segment selector |
| size_i | input | 2 | Destination width: 0=16, 1=32, 2/3=64 |
| cpl_i | input | 2 | Current privilege level |
| dest_i | input | 64 | Present destination register value |
| gtab_base_i | input | ADDR_W | Global table base address |
| gtab_limit_i | input | LIM_W | Global table limit (last valid byte offset) |
| ltab_base_i | input | ADDR_W | Local table base address |
| ltab_limit_i | input | LIM_W | Local table limit |
| mem_req_o | output | 1 | Read request valid |
| mem_addr_o | output | ADDR_W | Read byte address |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor upper word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| zf_o | output | 1 | Success flag |
| result_o | output | 64 | Updated destination value |

## Verification
Two events can land in the same clock edge: a new `start_i` arriving, and either the loader's in-flight memory exchange or its completion cycle. The bench provokes this in two ways. It holds `start_i` high for a second cycle with a different selector while the loader is checking. It also raises `start_i` exactly in the cycle where `done_o` is seen. Each case is judged by three observations:
- the completed result still matches the model for the first selector;
- exactly one request handshake occurred;
- after the collision `busy_o` stays low and no further `done_o` appears.

// File: rtl/slr_pkg.sv
package slr_pkg;

  typedef enum logic [1:0] {
    SZ16 = 2'd0,
    SZ32 = 2'd1,
    SZ64 = 2'd2,
    SZ64B = 2'd3
  } dst_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_RESP,
    ST_DONE
  } ld_state_e;

  localparam logic [31:0] RIGHTS_MASK32 = 32'h00FF_FF00;

  // System/gate type codes that may be inspected
  function automatic logic sys_type_ok(input logic [3:0] t);
    case (t)
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h9, 4'hB, 4'hC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/slr_check.sv
module slr_check #(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 16
) (
  input  logic [15:0]       sel_i,
  input  logic [ADDR_W-1:0] gtab_base_i,
  input  logic [LIM_W-1:0]  gtab_limit_i,
  input  logic [ADDR_W-1:0] ltab_base_i,
  input  logic [LIM_W-1:0]  ltab_limit_i,
  output logic              reach_ok_o,
  output logic [ADDR_W-1:0] fetch_addr_o
);
  localparam int CMP_W = ((LIM_W > 16) ? LIM_W : 16) + 1;

  logic              use_local;
  logic              is_null;
  logic [15:0]       byte_ofs;
  logic [CMP_W-1:0]  last_byte;
  logic [CMP_W-1:0]  lim_ext;
  logic [ADDR_W-1:0] base_sel;

  always_comb begin
    use_local    = sel_i[2];
    is_null      = (sel_i[15:2] == 14'd0);
    byte_ofs     = {sel_i[15:3], 3'b000};
    last_byte    = CMP_W'(byte_ofs) + CMP_W'(7);
    lim_ext      = use_local ? CMP_W'(ltab_limit_i) : CMP_W'(gtab_limit_i);
    base_sel     = use_local ? ltab_base_i : gtab_base_i;
    reach_ok_o   = !is_null && (last_byte <= lim_ext);
    fetch_addr_o = base_sel + ADDR_W'(byte_ofs) + ADDR_W'(4);
  end

endmodule

// File: rtl/slr_eval.sv
module slr_eval
  import slr_pkg::*;
(
  input  logic [31:0] word_i,
  input  logic [1:0]  rpl_i,
  input  logic [1:0]  cpl_i,
  input  dst_size_e   size_i,
  input  logic [63:0] dest_i,
  output logic        pass_o,
  output logic [63:0] result_o
);
  logic       is_seg;
  logic [3:0] typ;
  logic [1:0] dpl;
  logic [1:0] eff_pl;
  logic       conforming;
  logic       type_ok;
  logic       priv_ok;
  logic [31:0] masked32;

  always_comb begin
    is_seg     = word_i[12];
    typ        = word_i[11:8];
    dpl        = word_i[14:13];
    eff_pl     = (cpl_i > rpl_i) ? cpl_i : rpl_i;
    conforming = is_seg && typ[3] && typ[2];
    type_ok    = is_seg || sys_type_ok(typ);
    priv_ok    = conforming || (dpl >= eff_pl);
    pass_o     = type_ok && priv_ok;
    masked32   = word_i & RIGHTS_MASK32;
    unique case (size_i)
      SZ16:    result_o = {dest_i[63:16], word_i[15:8], 8'h00};
      SZ32:    result_o = {dest_i[63:32], masked32};
      default: result_o = {32'h0, masked32};
    endcase
  end

endmodule

// File: rtl/seg_rights_loader.sv
module seg_rights_loader
  import slr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [15:0]       sel_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        cpl_i,
  input  logic [63:0]       dest_i,
  input  logic [ADDR_W-1:0] gtab_base_i,
  input  logic [LIM_W-1:0]  gtab_limit_i,
  input  logic [ADDR_W-1:0] ltab_base_i,
  input  logic [LIM_W-1:0]  ltab_limit_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              zf_o,
  output logic [63:0]       result_o
);

  ld_state_e         state_q, state_d;
  logic [15:0]       sel_q;
  dst_size_e         size_q;
  logic [1:0]        cpl_q;
  logic [63:0]       dest_q;
  logic [ADDR_W-1:0] addr_q;
  logic              zf_q, zf_d;
  logic [63:0]       res_q, res_d;
  logic              cap_en, addr_en, out_en;

  logic              chk_ok;
  logic [ADDR_W-1:0] chk_addr;
  logic              ev_pass;
  logic [63:0]       ev_result;

  slr_check #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_check (
    .sel_i        (sel_q),
    .gtab_base_i  (gtab_base_i),
    .gtab_limit_i (gtab_limit_i),
    .ltab_base_i  (ltab_base_i),
    .ltab_limit_i (ltab_limit_i),
    .reach_ok_o   (chk_ok),
    .fetch_addr_o (chk_addr)
  );

  slr_eval u_eval (
    .word_i   (mem_rdata_i),
    .rpl_i    (sel_q[1:0]),
    .cpl_i    (cpl_q),
    .size_i   (size_q),
    .dest_i   (dest_q),
    .pass_o   (ev_pass),
    .result_o (ev_result)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    addr_en = 1'b0;
    out_en  = 1'b0;
    zf_d    = zf_q;
    res_d   = res_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_CHECK;
          cap_en  = 1'b1;
        end
      end
      ST_CHECK: begin
        if (chk_ok) begin
          state_d = ST_REQ;
          addr_en = 1'b1;
        end else begin
          state_d = ST_DONE;
          out_en  = 1'b1;
          zf_d    = 1'b0;
          res_d   = dest_q;
        end
      end
      ST_REQ: begin
        if (mem_ready_i) state_d = ST_RESP;
      end
      ST_RESP: begin
        if (mem_rvalid_i) begin
          state_d = ST_DONE;
          out_en  = 1'b1;
          zf_d    = ev_pass;
          res_d   = ev_pass ? ev_result : dest_q;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      size_q  <= SZ16;
      cpl_q   <= '0;
      dest_q  <= '0;
      addr_q  <= '0;
      zf_q    <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        sel_q  <= sel_i;
        size_q <= dst_size_e'(size_i);
        cpl_q  <= cpl_i;
        dest_q <= dest_i;
      end
      if (addr_en) addr_q <= chk_addr;
      if (out_en) begin
        zf_q  <= zf_d;
        res_q <= res_d;
      end
    end
  end

  assign mem_req_o  = (state_q == ST_REQ);
  assign mem_addr_o = addr_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign zf_o       = zf_q;
  assign result_o   = res_q;

  // Null selector never reaches the memory port
  assert_null_noreq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && sel_q[15:2] == 14'd0) |=> !mem_req_o);

  // Request held with stable address until accepted
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // 16-bit success image has a clear low byte
  assert_res16_lowbyte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && zf_o && size_q == SZ16) |-> (result_o[7:0] == 8'h00));

  // 64-bit success image is zero-extended
  assert_res64_zext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && zf_o && size_q[1]) |-> (result_o[63:24] == 40'h0));

  // Completion pulse is exactly one cycle
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // A start during the completion cycle launches nothing
  assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

endmodule

// File: tb/seg_rights_loader_tb.sv
module seg_rights_loader_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] sel_i = '0;
  logic [1:0]  size_i = '0;
  logic [1:0]  cpl_i = '0;
  logic [63:0] dest_i = '0;
  logic [31:0] gtab_base_i = 32'h0001_0000;
  logic [15:0] gtab_limit_i = 16'h00FF;
  logic [31:0] ltab_base_i = 32'h0020_0000;
  logic [15:0] ltab_limit_i = 16'h003F;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_ready_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        busy_o, done_o, zf_o;
  logic [63:0] result_o;

  int          checks = 0;
  int          errors = 0;
  int          hs_cnt = 0;
  logic [31:0] hs_addr = '0;
  logic [31:0] mem_word = '0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  seg_rights_loader dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
    .size_i(size_i), .cpl_i(cpl_i), .dest_i(dest_i),
    .gtab_base_i(gtab_base_i), .gtab_limit_i(gtab_limit_i),
    .ltab_base_i(ltab_base_i), .ltab_limit_i(ltab_limit_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_ready_i(mem_ready_i), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .zf_o(zf_o), .result_o(result_o)
  );

  // Memory responder: random accept delay, data one cycle after accept
  always @(negedge clk) begin
    mem_rvalid_i = 1'b0;
    if (mem_ready_i) begin
      mem_ready_i  = 1'b0;
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = mem_word;
    end else if (mem_req_o && ($urandom % 3 == 0)) begin
      mem_ready_i = 1'b1;
      hs_cnt++;
      hs_addr = mem_addr_o;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model
  function automatic bit m_reach(input logic [15:0] s, input logic [15:0] gl, input logic [15:0] ll);
    logic [16:0] last;
    logic [15:0] lim;
    if (s[15:2] == 14'd0) return 1'b0;
    lim  = s[2] ? ll : gl;
    last = {1'b0, s[15:3], 3'b000} + 17'd7;
    return last <= {1'b0, lim};
  endfunction

  function automatic logic [31:0] m_addr(input logic [15:0] s);
    return (s[2] ? ltab_base_i : gtab_base_i) + {16'h0, s[15:3], 3'b000} + 32'd4;
  endfunction

  function automatic bit m_ok(input logic [15:0] s, input logic [1:0] cpl, input logic [31:0] w);
    bit sysok, conf;
    logic [1:0] eff;
    case (w[11:8])
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h9, 4'hB, 4'hC: sysok = 1'b1;
      default: sysok = 1'b0;
    endcase
    conf = w[12] & w[11] & w[10];
    eff  = (cpl > s[1:0]) ? cpl : s[1:0];
    return (w[12] || sysok) && (conf || (w[14:13] >= eff));
  endfunction

  function automatic logic [63:0] m_res(input logic [1:0] sz, input logic [31:0] w, input logic [63:0] d);
    case (sz)
      2'd0:    return {d[63:16], w[15:8], 8'h00};
      2'd1:    return {d[63:32], w & 32'h00FF_FF00};
      default: return {32'h0, w & 32'h00FF_FF00};
    endcase
  endfunction

  // One operation; spur=1 holds start a second cycle with another selector,
  // spur_done=1 raises start in the done cycle.
  task automatic run_op(input logic [15:0] s, input logic [1:0] sz, input logic [1:0] cpl,
                        input logic [31:0] w, input logic [63:0] d, input string req,
                        input bit spur, input bit spur_done);
    int hs0;
    bit reach, ok, seen;
    logic [63:0] exp;
    reach = m_reach(s, gtab_limit_i, ltab_limit_i);
    ok    = reach && m_ok(s, cpl, w);
    exp   = ok ? m_res(sz, w, d) : d;
    @(negedge clk);
    sel_i = s; size_i = sz; cpl_i = cpl; dest_i = d; mem_word = w;
    hs0 = hs_cnt;
    start_i = 1'b1;
    @(negedge clk);
    if (spur) begin
      sel_i  = s ^ 16'h0808;
      dest_i = ~d;
    end else start_i = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done_o) begin seen = 1'b1; break; end
      @(negedge clk);
      start_i = 1'b0;
    end
    check(seen, {req, " R11 done"}, 64'(seen), 64'd1);
    check(zf_o == ok, {req, " R11 zf"}, 64'(zf_o), 64'(ok));
    check(result_o == exp, {req, " result"}, result_o, exp);
    check(hs_cnt - hs0 == (reach ? 1 : 0), {req, " R4 handshakes"}, 64'(hs_cnt - hs0), 64'(reach));
    if (reach) check(hs_addr == m_addr(s), {req, " R3 address"}, 64'(hs_addr), 64'(m_addr(s)));
    if (spur_done) begin
      start_i = 1'b1;
      sel_i   = 16'h0010;
      @(negedge clk);
      start_i = 1'b0;
      check(!busy_o && !done_o, "R12 start in done cycle", 64'(busy_o), 64'd0);
      @(negedge clk);
      @(negedge clk);
      check(!busy_o && !done_o, "R12 no late launch", 64'(done_o), 64'd0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!done_o && !zf_o && result_o == 64'h0 && !mem_req_o && !busy_o,
          "reset state", result_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 null selectors, any RPL
    run_op(16'h0003, 2'd1, 2'd0, 32'h00CF_9A00, 64'h1111_2222_3333_4444, "R1 null rpl3", 0, 0);
    run_op(16'h0000, 2'd2, 2'd0, 32'h00CF_9A00, 64'hAAAA_BBBB_CCCC_DDDD, "R1 null", 0, 0);
    // R3 local index 0 is not null
    run_op(16'h0004, 2'd1, 2'd0, 32'h00C0_F200, 64'h0, "R3 local idx0", 0, 0);
    // R2 limit boundary: index 5 needs limit >= 47
    gtab_limit_i = 16'd47;
    run_op(16'h0028, 2'd1, 2'd0, 32'h00C0_9200, 64'h5, "R2 limit exact", 0, 0);
    gtab_limit_i = 16'd46;
    run_op(16'h0028, 2'd1, 2'd0, 32'h00C0_9200, 64'h5, "R2 limit short", 0, 0);
    gtab_limit_i = 16'h00FF;
    ltab_limit_i = 16'd7;
    run_op(16'h000C, 2'd1, 2'd0, 32'h00C0_9200, 64'h6, "R2 local beyond", 0, 0);
    ltab_limit_i = 16'h003F;
    // R5, R6 every type code, system and non-system
    for (int t = 0; t < 16; t++) begin
      run_op(16'h0010, 2'd1, 2'd0, 32'h0000_E000 | (32'(t) << 8), 64'h7, "R6 system type", 0, 0);
      run_op(16'h0010, 2'd1, 2'd0, 32'h0000_F000 | (32'(t) << 8), 64'h8, "R5 code/data type", 0, 0);
    end
    // R7 privilege
    run_op(16'h0010, 2'd1, 2'd3, 32'h0000_9A00, 64'h9, "R7 nonconf dpl0 cpl3", 0, 0);
    run_op(16'h0010, 2'd1, 2'd3, 32'h0000_9E00, 64'h9, "R7 conforming exempt", 0, 0);
    run_op(16'h0012, 2'd1, 2'd1, 32'h0000_B200, 64'h9, "R7 rpl2 dpl1", 0, 0);
    run_op(16'h0012, 2'd1, 2'd1, 32'h0000_D200, 64'h9, "R7 rpl2 dpl2", 0, 0);
    // R8 R9 R10 masking per size
    run_op(16'h0018, 2'd0, 2'd0, 32'hFFFF_FFFF, 64'h0123_4567_89AB_CDEF, "R9 size16", 0, 0);
    run_op(16'h0018, 2'd1, 2'd0, 32'hFFFF_FFFF, 64'h0123_4567_89AB_CDEF, "R8 size32", 0, 0);
    run_op(16'h0018, 2'd2, 2'd0, 32'hFFFF_FFFF, 64'h0123_4567_89AB_CDEF, "R10 size64", 0, 0);
    run_op(16'h0018, 2'd3, 2'd0, 32'hFFFA_FFFF, 64'h0123_4567_89AB_CDEF, "R10 size64 alt", 0, 0);
    // R12 collisions with busy / done cycle
    run_op(16'h0020, 2'd1, 2'd0, 32'h00CF_9300, 64'hF0F0, "R12 start while checking", 1, 0);
    run_op(16'h0000, 2'd1, 2'd0, 32'h00CF_9300, 64'hF0F1, "R12 start on null path", 1, 0);
    run_op(16'h0024, 2'd2, 2'd0, 32'h00CF_9300, 64'hF0F2, "R12 start in done", 0, 1);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] s;
      logic [31:0] w;
      s = {3'b000, 10'($urandom % 12), 3'($urandom)};
      w = $urandom;
      run_op(s, 2'($urandom), 2'($urandom), w, {$urandom, $urandom}, "random",
             ($urandom % 8) == 0, ($urandom % 16) == 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule